// File: doc/BRIEF.md
# One-Bit Framebuffer Pixel Scanout

This block converts a packed monochrome framebuffer into a 24-bit colour pixel stream for a raster display. Each framebuffer word holds sixteen horizontally adjacent pixels at one bit each. The framebuffer is 512 columns by 256 rows, which is 8192 words. A video timing generator supplies the current column and row counters. The raster those counters sweep may be larger than the framebuffer.

From the counters the block computes the word address for a synchronous screen memory. That memory returns the word one clock later. The block picks one bit of the returned word and drives either full white or full black. Everything outside the framebuffer area is blanked. To make up for the read latency, the block takes the bit index from the column one before the current one. The first column of every line therefore shows the last bit of whatever word was fetched on the clock before it.

Each cycle, a combinational classifier places the counters in one of three regions. `SCAN_PIXEL` means inside the framebuffer. `SCAN_HBLANK` means column 512 or beyond with the row inside. `SCAN_VBLANK` means row 256 or beyond. The region moves from `SCAN_PIXEL` to `SCAN_HBLANK` when the column reaches 512. It moves back to `SCAN_PIXEL` when the column wraps to 0 on a row below 256. It enters `SCAN_VBLANK` when the row reaches 256, and it returns to `SCAN_PIXEL` when the row wraps to 0. The block holds no state of its own, so the region is re-derived every clock.

Top module: `fbscan_mono`

## Requirements
- R1: `mem_addr` equals (row × 32 + column ÷ 16) modulo 8192, computed in the same cycle as the counters it is derived from.
- R2: While the row stays the same and the column advances inside one aligned group of 16 columns, `mem_addr` does not change.
- R3: Inside the framebuffer area (column below 512 and row below 256), `rgb` is 24'hFFFFFF when the selected bit is 1 and 24'h000000 when it is 0.
- R4: The selected bit is bit ((column − 1) mod 16) of `mem_data`, where `mem_data` is the word the memory returns for the address presented on the previous clock. Bit 0 is the leftmost pixel of a 16-pixel group. With counters advancing one column per clock, column c therefore shows framebuffer column c − 1 of the current row.
- R5: When the column is 512 or more, `rgb` is 24'h000000 whatever `mem_data` holds.
- R6: When the row is 256 or more, `rgb` is 24'h000000 whatever `mem_data` holds.
- R7: At column 0 of an active row, `rgb` follows bit 15 of the word returned for the address presented on the previous clock. That address comes from the last column of the preceding line.
- R8: At column 16 of an active row, `rgb` follows bit 15 of the row's word 0, which is the word fetched while the column was 15.
- R9: `rgb` only ever takes the values 24'h000000 and 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge; screen memory and counters share it |
| rst_n | input | 1 | Active-low reset; qualifies the embedded checks only |
| h_pos | input | 11 | Current column counter from the timing generator |
| v_pos | input | 10 | Current row counter from the timing generator |
| mem_addr | output | 13 | Word address presented to the screen memory |
| mem_data | input | 16 | Word returned by the screen memory one clock after its address |
| rgb | output | 24 | Pixel colour, 8 bits per channel |

## Verification
The only internal state that can go wrong here is the region classification and the bit index. A misclassified region shows at once as a lit pixel in the blanking area or a black stripe inside the picture, on the very cycle the counters cross 512 or 256. An index that is off by one, or that is not corrected for latency, shows within one clock as every pixel taking its neighbour's value. An error in the address arithmetic shows on the same cycle at `mem_addr`, and one clock later as the wrong word's bits at `rgb`. The boundary columns 0 and 16 show whether the wrap of the corrected index picks up the word fetched on the preceding clock.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

    // Where the current counters fall relative to the framebuffer area.
    typedef enum logic [1:0] {
        SCAN_PIXEL  = 2'd0,
        SCAN_HBLANK = 2'd1,
        SCAN_VBLANK = 2'd2
    } scan_region_e;

endpackage

// File: rtl/fbscan_addr.sv
module fbscan_addr #(
    parameter int XW     = 11,
    parameter int YW     = 10,
    parameter int ADDR_W = 13,
    parameter int ROW_SH = 5,
    parameter int COL_SH = 4
) (
    input  logic [XW-1:0]     h_pos,
    input  logic [YW-1:0]     v_pos,
    output logic [ADDR_W-1:0] word_addr
);

    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] col_word;

    // Row base: each framebuffer row spans 2**ROW_SH words.
    always_comb begin
        row_base = ADDR_W'(v_pos) << ROW_SH;
    end

    // Column word: every 2**COL_SH columns share one word.
    always_comb begin
        col_word = ADDR_W'(h_pos >> COL_SH);
    end

    always_comb begin
        word_addr = row_base + col_word;
    end

endmodule

// File: rtl/fbscan_region.sv
module fbscan_region
    import fbscan_pkg::*;
#(
    parameter int XW   = 11,
    parameter int YW   = 10,
    parameter int FB_W = 512,
    parameter int FB_H = 256
) (
    input  logic [XW-1:0] h_pos,
    input  logic [YW-1:0] v_pos,
    output scan_region_e  region
);

    logic row_out;
    logic col_out;

    always_comb begin
        row_out = (32'(v_pos) >= FB_H);
        col_out = (32'(h_pos) >= FB_W);
    end

    // Row overflow outranks column overflow.
    always_comb begin
        if (row_out) begin
            region = SCAN_VBLANK;
        end else if (col_out) begin
            region = SCAN_HBLANK;
        end else begin
            region = SCAN_PIXEL;
        end
    end

endmodule

// File: rtl/fbscan_pick.sv
module fbscan_pick
    import fbscan_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int COL_SH = 4,
    parameter int RGB_W  = 24
) (
    input  scan_region_e      region,
    input  logic [COL_SH-1:0] col_lo,
    input  logic [WORD_W-1:0] word,
    output logic [RGB_W-1:0]  rgb
);

    logic [COL_SH-1:0] bit_idx;
    logic              pix_on;

    // The word on the bus was requested one column earlier, so the
    // index steps back by one (wrapping 0 -> WORD_W-1).
    always_comb begin
        bit_idx = col_lo - 1'b1;
        pix_on  = word[bit_idx];
    end

    always_comb begin
        unique case (region)
            SCAN_PIXEL:  rgb = pix_on ? {RGB_W{1'b1}} : '0;
            SCAN_HBLANK: rgb = '0;
            SCAN_VBLANK: rgb = '0;
            default:     rgb = '0;
        endcase
    end

endmodule

// File: rtl/fbscan_mono.sv
module fbscan_mono
    import fbscan_pkg::*;
#(
    parameter int FB_W   = 512,
    parameter int FB_H   = 256,
    parameter int WORD_W = 16,
    parameter int XW     = 11,
    parameter int YW     = 10,
    parameter int RGB_W  = 24,
    localparam int WORDS_PER_ROW = FB_W / WORD_W,
    localparam int ROW_SH        = $clog2(WORDS_PER_ROW),
    localparam int COL_SH        = $clog2(WORD_W),
    localparam int ADDR_W        = $clog2(FB_W * FB_H / WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     h_pos,
    input  logic [YW-1:0]     v_pos,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_data,
    output logic [RGB_W-1:0]  rgb
);

    scan_region_e region;

    fbscan_addr #(
        .XW(XW), .YW(YW), .ADDR_W(ADDR_W), .ROW_SH(ROW_SH), .COL_SH(COL_SH)
    ) u_addr (
        .h_pos(h_pos),
        .v_pos(v_pos),
        .word_addr(mem_addr)
    );

    fbscan_region #(
        .XW(XW), .YW(YW), .FB_W(FB_W), .FB_H(FB_H)
    ) u_region (
        .h_pos(h_pos),
        .v_pos(v_pos),
        .region(region)
    );

    fbscan_pick #(
        .WORD_W(WORD_W), .COL_SH(COL_SH), .RGB_W(RGB_W)
    ) u_pick (
        .region(region),
        .col_lo(h_pos[COL_SH-1:0]),
        .word(mem_data),
        .rgb(rgb)
    );

    // R5 R6
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region != SCAN_PIXEL) |-> (rgb == '0));

    // R9
    two_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb == '0) || (rgb == {RGB_W{1'b1}}));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_pos[COL_SH-1:0] != '0) && (h_pos == $past(h_pos) + 1'b1)
         && (v_pos == $past(v_pos))) |-> $stable(mem_addr));

    // R4
    latency_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((region == SCAN_PIXEL) && (h_pos == $past(h_pos) + 1'b1))
        |-> (rgb[0] == mem_data[$past(h_pos[COL_SH-1:0])]));

    // R1
    row_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == SCAN_PIXEL)
        |-> (mem_addr[ADDR_W-1:ROW_SH] == v_pos[ADDR_W-ROW_SH-1:0]));

endmodule

// File: tb/fbscan_mono_tb.sv
module fbscan_mono_tb;

    localparam int H_TOT = 544;
    localparam int V_TOT = 264;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] h_pos = '0;
    logic [9:0]  v_pos = '0;
    logic [12:0] mem_addr;
    logic [15:0] mem_data = '0;
    logic [23:0] rgb;

    int n_chk = 0;
    int n_bad = 0;
    int px = 0;
    int py = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fbscan_mono u_dut (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
        .mem_addr(mem_addr), .mem_data(mem_data), .rgb(rgb)
    );

    function automatic logic [15:0] pattern(input int a);
        int t;
        t = (a * 32'h2F5B) ^ 32'hA5C3 ^ (a >> 3);
        return t[15:0];
    endfunction

    function automatic int addr_of(input int x, input int y);
        return ((y << 5) + (x >> 4)) & 8191;
    endfunction

    // One-clock-latency screen memory holding a computed pattern.
    always_ff @(posedge clk) begin
        mem_data <= pattern(int'(mem_addr));
    end

    function automatic logic [23:0] exp_rgb(input int qx, input int qy,
                                            input int x, input int y);
        logic [15:0] w;
        if (x >= 512 || y >= 256) return 24'h0;
        w = pattern(addr_of(qx, qy));
        return w[(x - 1) & 15] ? 24'hFFFFFF : 24'h0;
    endfunction

    task automatic check(input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive new counters after a falling edge, check, then remember them.
    task automatic step(input int x, input int y, input string tag, input bit chk);
        @(negedge clk);
        h_pos = 11'(x);
        v_pos = 10'(y);
        #1;
        if (chk) begin
            check({tag, " pixel"}, rgb, exp_rgb(px, py, x, y));
            check("R1 addr", {11'd0, mem_addr}, 24'(addr_of(x, y)));
            check("R9 level", 24'((rgb == 24'h0) || (rgb == 24'hFFFFFF)), 24'd1);
        end
        px = x;
        py = y;
    endtask

    // Directed vectors: {prev col, prev row, col, row}
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{543, 9,   0,   10},
        '{15,  5,   16,  5},
        '{100, 20,  101, 20},
        '{511, 255, 512, 255},
        '{600, 40,  601, 40},
        '{33,  255, 34,  256},
        '{10,  300, 11,  300},
        '{31,  0,   32,  0}
    };

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [12:0] grp_addr;
        // Reset state: outside area gives black (R5), in-area formula holds (R1).
        h_pos = 11'd600;
        v_pos = 10'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R5 reset blank", rgb, 24'h0);
        check("R1 reset addr", {11'd0, mem_addr}, 24'(addr_of(600, 3)));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][0], VEC[i][1], "table", 1'b0);
            step(VEC[i][2], VEC[i][3], "R3 R4 R5 R6 R7 R8 table", 1'b1);
        end

        // R7: column 0 takes bit 15 of the word fetched at the previous line end.
        step(543, 77, "prep", 1'b0);
        step(0, 78, "R7 col0", 1'b1);
        check("R7 col0 word", rgb, pattern(addr_of(543, 77))[15] ? 24'hFFFFFF : 24'h0);

        // R8: column 16 takes bit 15 of word 0 of the row.
        for (int x = 0; x <= 16; x++) step(x, 130, "R4 run", 1'b1);
        check("R8 col16 word", rgb, pattern(addr_of(0, 130))[15] ? 24'hFFFFFF : 24'h0);

        // R2: address constant across one 16-column group.
        step(32, 61, "R2 group start", 1'b1);
        grp_addr = mem_addr;
        for (int x = 33; x < 48; x++) begin
            step(x, 61, "R2 group", 1'b1);
            check("R2 hold", {11'd0, mem_addr}, {11'd0, grp_addr});
        end

        // Full raster sweep.
        for (int y = 0; y < V_TOT; y++) begin
            for (int x = 0; x < H_TOT; x++) begin
                if (y >= 256)      step(x, y, "R6 sweep", 1'b1);
                else if (x >= 512) step(x, y, "R5 sweep", 1'b1);
                else if (x == 0)   step(x, y, "R7 sweep", 1'b1);
                else if (x == 16)  step(x, y, "R8 sweep", 1'b1);
                else               step(x, y, "R3 R4 sweep", 1'b1);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule